// File: doc/BRIEF.md
# Completion Queue Poster with Phase Tag

This block is the controller-side producer for one circular completion ring kept in host memory. A request carrying a command identifier, the submitting queue's identifier, the current submission head and a status code is turned into a 16-byte entry. The entry is presented as a single write aimed at the ring's tail slot, and the tail then moves on by one slot. Each entry also carries a one-bit phase tag, and the block inverts that tag every time the tail wraps from the last slot back to slot 0. Host software can therefore tell a fresh entry from a stale one by its tag alone, without reading any register.

The host returns the ring slots it has consumed by writing its new head index through a doorbell. The block keeps that head value and stops accepting requests while one more entry would catch up with it. One slot is always left empty, so a full ring and an empty ring never look the same. The write port has a valid/ready handshake and holds at most one entry in flight.

Top module: `cq_poster`

## Requirements
- R1: After reset `wr_valid` is 0, `req_ready` is 1, `q_full` is 0, and the first entry goes to slot 0 with phase bit 1.
- R2: The entry on `wr_data` is laid out as follows. Bits 31:0 carry `req_spec`, bits 63:32 are zero, bits 79:64 carry `req_sqhd`, bits 95:80 carry `req_sqid`, bits 111:96 carry `req_cid`, bit 112 is the phase bit and bits 127:113 carry `req_status`.
- R3: `wr_addr` equals `BASE + 16 * slot`. Successive entries use successive slots.
- R4: After slot DEPTH-1 the tail goes back to slot 0, and the phase bit inverts at that wrap and at no other point.
- R5: `q_full` is 1 exactly when (tail + 1) mod DEPTH equals the stored head. While it is 1, `req_ready` is 0 and no request is taken.
- R6: A doorbell write with a value below DEPTH replaces the stored head. Any slots it frees count from the edge where the doorbell is sampled.
- R7: A doorbell value of DEPTH or more is ignored and leaves the stored head unchanged.
- R8: While `wr_valid` is 1 and `wr_ready` is 0, the entry and its address stay constant and `req_ready` is 0.
- R9: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. Its entry appears on `wr_valid` from that edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Completion request present |
| req_ready | output | 1 | Request is taken on this edge if valid |
| req_cid | input | 16 | Command identifier |
| req_sqid | input | 16 | Submission queue identifier |
| req_sqhd | input | 16 | Current submission head index |
| req_status | input | 15 | Status code |
| req_spec | input | 32 | Command-specific word |
| db_valid | input | 1 | Host head doorbell write |
| db_head | input | 16 | New head index from the host |
| wr_valid | output | 1 | Entry write pending |
| wr_ready | input | 1 | Memory side takes the write |
| wr_addr | output | ADDR_W | Byte address of the target slot |
| wr_data | output | 128 | Formatted 16-byte entry |
| q_full | output | 1 | Ring has no free slot |

## Verification
A request taken at a rising edge shows up on `wr_valid`, `wr_addr` and `wr_data` right after that same edge, so the results are due one edge after the request. A doorbell or an acceptance changes `q_full` and `req_ready` one edge later as well. The reference model steps at each rising edge using the inputs the bench drove at the previous falling edge, and it compares every output 2 ns after that edge. The directed checks sample at the falling edge that follows the edge under test. That falling edge comes before the bench drives any new input.

// File: rtl/cqp_pkg.sv
package cqp_pkg;

    localparam int ENTRY_BYTES = 16;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

    typedef struct packed {
        logic [14:0] status;
        logic        phase;
        logic [15:0] cid;
        logic [15:0] sqid;
        logic [15:0] sqhd;
        logic [31:0] rsvd;
        logic [31:0] spec;
    } cq_entry_t;

endpackage

// File: rtl/cqp_ring_ptr.sv
module cqp_ring_ptr #(
    parameter int DEPTH = 6,
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             db_valid,
    input  logic [15:0]      db_head,
    output logic [PTR_W-1:0] tail,
    output logic             phase,
    output logic             full
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] tail;
        logic [PTR_W-1:0] head;
        logic             phase;
    } ring_t;

    ring_t            r_d, r_q;
    logic [PTR_W-1:0] tail_inc;

    always_comb begin
        tail_inc = (r_q.tail == LAST) ? '0 : r_q.tail + 1'b1;
        r_d      = r_q;
        if (adv) begin
            r_d.tail = tail_inc;
            if (r_q.tail == LAST) r_d.phase = ~r_q.phase;
        end
        if (db_valid && (db_head < 16'(DEPTH))) r_d.head = db_head[PTR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.tail  <= '0;
            r_q.head  <= '0;
            r_q.phase <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign tail  = r_q.tail;
    assign phase = r_q.phase;
    assign full  = (tail_inc == r_q.head);

    assert_wrap_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && r_q.tail == LAST) |=> (r_q.tail == '0 && r_q.phase != $past(r_q.phase)));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && r_q.tail != LAST) |=> (r_q.tail == $past(r_q.tail) + 1'b1 && $stable(r_q.phase)));

    assert_bad_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (db_valid && db_head >= 16'(DEPTH)) |=> $stable(r_q.head));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(r_q.tail) && $stable(r_q.phase)));

endmodule

// File: rtl/cqp_entry_fmt.sv
module cqp_entry_fmt
    import cqp_pkg::*;
#(
    parameter int                ADDR_W = 48,
    parameter logic [ADDR_W-1:0] BASE   = '0,
    parameter int                PTR_W  = 3
) (
    input  logic [PTR_W-1:0]  slot,
    input  logic              phase,
    input  logic [15:0]       cid,
    input  logic [15:0]       sqid,
    input  logic [15:0]       sqhd,
    input  logic [14:0]       status,
    input  logic [31:0]       spec,
    output cq_entry_t         entry,
    output logic [ADDR_W-1:0] slot_addr
);
    always_comb begin
        entry.status = status;
        entry.phase  = phase;
        entry.cid    = cid;
        entry.sqid   = sqid;
        entry.sqhd   = sqhd;
        entry.rsvd   = '0;
        entry.spec   = spec;
        slot_addr    = BASE + (ADDR_W'(slot) << ENTRY_SHIFT);
    end
endmodule

// File: rtl/cq_poster.sv
module cq_poster
    import cqp_pkg::*;
#(
    parameter int                DEPTH  = 6,
    parameter int                ADDR_W = 48,
    parameter logic [ADDR_W-1:0] BASE   = 48'h0000_8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [15:0]       req_cid,
    input  logic [15:0]       req_sqid,
    input  logic [15:0]       req_sqhd,
    input  logic [14:0]       req_status,
    input  logic [31:0]       req_spec,
    input  logic              db_valid,
    input  logic [15:0]       db_head,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [127:0]      wr_data,
    output logic              q_full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        cq_entry_t         ent;
    } out_t;

    out_t              o_d, o_q;
    logic              accept;
    logic              full;
    logic              phase;
    logic [PTR_W-1:0]  tail;
    cq_entry_t         new_ent;
    logic [ADDR_W-1:0] new_addr;

    cqp_ring_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (accept),
        .db_valid (db_valid),
        .db_head  (db_head),
        .tail     (tail),
        .phase    (phase),
        .full     (full)
    );

    cqp_entry_fmt #(.ADDR_W(ADDR_W), .BASE(BASE), .PTR_W(PTR_W)) u_fmt (
        .slot      (tail),
        .phase     (phase),
        .cid       (req_cid),
        .sqid      (req_sqid),
        .sqhd      (req_sqhd),
        .status    (req_status),
        .spec      (req_spec),
        .entry     (new_ent),
        .slot_addr (new_addr)
    );

    always_comb begin
        req_ready = !full && (!o_q.vld || wr_ready);
        accept    = req_valid && req_ready;
        o_d       = o_q;
        if (wr_ready) o_d.vld = 1'b0;
        if (accept) begin
            o_d.vld  = 1'b1;
            o_d.addr = new_addr;
            o_d.ent  = new_ent;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign wr_valid = o_q.vld;
    assign wr_addr  = o_q.addr;
    assign wr_data  = o_q.ent;
    assign q_full   = full;

    assert_full_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !req_ready);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));

    assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |-> !req_ready);

    assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> wr_valid);

endmodule

// File: tb/cq_poster_test.sv
`timescale 1ns/1ps
module cq_poster_test;
    localparam int          DEPTH = 6;
    localparam int          AW    = 48;
    localparam logic [47:0] BASE  = 48'h0000_8000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [15:0]   req_cid = '0, req_sqid = '0, req_sqhd = '0;
    logic [14:0]   req_status = '0;
    logic [31:0]   req_spec = '0;
    logic          db_valid = 1'b0;
    logic [15:0]   db_head = '0;
    logic          wr_valid;
    logic          wr_ready = 1'b1;
    logic [AW-1:0] wr_addr;
    logic [127:0]  wr_data;
    logic          q_full;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    cq_poster #(.DEPTH(DEPTH), .ADDR_W(AW), .BASE(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cid(req_cid), .req_sqid(req_sqid), .req_sqhd(req_sqhd),
        .req_status(req_status), .req_spec(req_spec), .db_valid(db_valid),
        .db_head(db_head), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .q_full(q_full)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int           m_tail, m_head, m_phase;
    bit           m_vld;
    logic [47:0]  m_addr;
    logic [127:0] m_data;
    bit           m_full;

    always @(posedge clk) begin
        bit rdy;
        cyc++;
        if (!rst_n) begin
            m_tail = 0; m_head = 0; m_phase = 1; m_vld = 0; m_addr = '0; m_data = '0;
        end else begin
            rdy = (((m_tail + 1) % DEPTH) != m_head) && (!m_vld || wr_ready);
            if (m_vld && wr_ready) m_vld = 0;
            if (req_valid && rdy) begin
                m_vld  = 1;
                m_addr = BASE + 48'(m_tail * 16);
                m_data = {req_status, m_phase[0], req_cid, req_sqid, req_sqhd, 32'h0, req_spec};
                if (m_tail == DEPTH - 1) begin
                    m_tail  = 0;
                    m_phase = 1 - m_phase;
                end else begin
                    m_tail = m_tail + 1;
                end
            end
            if (db_valid && db_head < DEPTH) m_head = int'(db_head);
        end
        #2;
        m_full = ((m_tail + 1) % DEPTH) == m_head;
        chk("R9 wr_valid", 128'(wr_valid), 128'(m_vld));
        chk("R5 q_full", 128'(q_full), 128'(m_full));
        chk("R5 req_ready", 128'(req_ready), 128'(!m_full && (!m_vld || wr_ready)));
        if (m_vld) begin
            chk("R2 wr_data", wr_data, m_data);
            chk("R3 wr_addr", 128'(wr_addr), 128'(m_addr));
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            errors++;
            $display("FAIL R9 watchdog actual=%0d expected<20000 cycles", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic set_req(input bit v);
        req_valid  = v;
        req_cid    = 16'($urandom);
        req_sqid   = 16'($urandom);
        req_sqhd   = 16'($urandom);
        req_status = 15'($urandom);
        req_spec   = $urandom;
    endtask

    logic [127:0] held;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset wr_valid", 128'(wr_valid), 128'(0));
        chk("R1 reset req_ready", 128'(req_ready), 128'(1));
        chk("R1 reset q_full", 128'(q_full), 128'(0));

        // fill: five entries make the six-slot ring full
        for (int i = 0; i < 5; i++) begin
            set_req(1);
            @(negedge clk);
            if (i == 0) begin
                chk("R1 first phase", 128'(wr_data[112]), 128'(1));
                chk("R1 first slot", 128'(wr_addr), 128'(BASE));
            end
        end
        chk("R5 full after fill", 128'(q_full), 128'(1));
        chk("R5 ready low when full", 128'(req_ready), 128'(0));
        repeat (3) begin set_req(1); @(negedge clk); end
        chk("R5 still full", 128'(q_full), 128'(1));

        // out-of-range doorbell
        db_valid = 1'b1; db_head = 16'd9;
        @(negedge clk);
        chk("R7 bad doorbell ignored", 128'(q_full), 128'(1));

        // valid doorbell frees slots
        db_head = 16'd2;
        set_req(1);
        @(negedge clk);
        db_valid = 1'b0;
        chk("R6 ready after doorbell", 128'(req_ready), 128'(1));
        set_req(1);
        @(negedge clk);
        chk("R3 last slot addr", 128'(wr_addr), 128'(BASE + 48'd80));
        chk("R4 phase before wrap", 128'(wr_data[112]), 128'(1));
        set_req(1);
        @(negedge clk);
        chk("R4 wrap slot", 128'(wr_addr), 128'(BASE));
        chk("R4 phase after wrap", 128'(wr_data[112]), 128'(0));
        set_req(0);
        @(negedge clk);
        chk("R5 full again", 128'(q_full), 128'(1));

        // drain ring, then backpressure
        db_valid = 1'b1; db_head = 16'd1;
        @(negedge clk);
        db_valid = 1'b0;
        wr_ready = 1'b0;
        set_req(1);
        @(negedge clk);
        held = wr_data;
        set_req(1);
        repeat (3) @(negedge clk);
        chk("R8 held valid", 128'(wr_valid), 128'(1));
        chk("R8 held data", wr_data, held);
        chk("R8 ready low", 128'(req_ready), 128'(0));
        wr_ready = 1'b1;
        set_req(0);
        @(negedge clk);
        chk("R8 drained", 128'(wr_valid), 128'(0));

        // random traffic checked by the model
        for (int n = 0; n < 400; n++) begin
            set_req(($urandom % 10) < 7);
            wr_ready = ($urandom % 4) != 0;
            db_valid = ($urandom % 5) == 0;
            db_head  = 16'($urandom % 8);
            @(negedge clk);
        end
        set_req(0);
        db_valid = 1'b0;
        wr_ready = 1'b1;
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule